// File: doc/BRIEF.md
# Crosspoint Routing Configuration Register

This block stores the routing map of a 16-output by 16-input crosspoint switch. For each output it keeps one entry of five bits. The entry has an enable flag and a 4-bit number that names the input routed to that output. The block produces only the digital select and enable lines. Each output has its own enable line and its own select field.

Storage has two ranks.

- **Staging rank.** Software-facing loads write here. There are two ways to load it, and both act on the falling edge of `sclk` while `ce_n` is low:
  - Serial load: an 80-bit stream goes into a shift chain and rewrites every entry. The bit leaving the chain appears on `sdo`, so several devices can be chained from one data line.
  - Parallel load: one addressed entry is rewritten and all other entries are left alone.
- **Live rank.** A level-sensitive latch that drives the outputs. It is transparent while `upd_n` is low, so one pulse on `upd_n` moves all staged entries to the outputs together. Keep `upd_n` high while loading so that partial patterns never reach the outputs.

Reset clears only the live rank. This disables every output without losing what was staged.

Top module: `xbar_cfg_regs`

## Requirements
- R1: While `ce_n` is low and `par_sel` is low (serial mode), each falling edge of `sclk` shifts `sdi` into the staging chain. A shift of 80 bits rewrites every entry.
- R2: The serial stream carries output 15's entry first and output 0's entry last. Within each entry the enable bit comes first, followed by the select bits, most significant first. In staging-chain terms, entry k is bits [5k+4:5k] with the enable at bit 5k+4.
- R3: The live rank follows the staging rank whenever `upd_n` is low. Output k drives `out_en[k]` and `out_sel[4k+3:4k]`.
- R4: While `upd_n` is high, the outputs hold, whatever is loaded into the staging rank.
- R5: While `ce_n` is high, neither serial shifting nor a parallel write changes the staging rank.
- R6: With `ce_n` low and `par_sel` high, a falling edge of `sclk` writes `wdata` into the entry addressed by `waddr`. Here `wdata[4]` is the enable and `wdata[3:0]` is the select. Every other entry keeps its value.
- R7: A low `rst_n` clears the live rank, so all enables and selects read 0. It leaves the staging rank intact, and a later update restores the staged routing.
- R8: `sdo` is the last stage of the chain and changes on the falling edge of `sclk`. While a new stream is shifted in, `sdo` presents the previously staged stream bit by bit in its original order.
- R9: An output whose enable bit is 0 shows a select of 0, whatever select bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Load clock; all staging activity on its falling edge |
| rst_n | input | 1 | Active-low reset of the live rank only |
| ce_n | input | 1 | Active-low chip enable for loading |
| par_sel | input | 1 | 0 = serial shift, 1 = parallel entry write |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, end of the shift chain |
| waddr | input | 4 | Output number for a parallel write |
| wdata | input | 5 | Parallel entry: bit 4 enable, bits 3:0 select |
| upd_n | input | 1 | Active-low transparent update of the live rank |
| out_en | output | 16 | Per-output enable |
| out_sel | output | 64 | Per-output input select, 4 bits per output |

## Verification
The bench loads patterns in which output numbers and select values differ, so a chain filled in reverse or with entry fields swapped shows up as outputs routed to the wrong inputs. It captures `sdo` during a second load and compares it to the first stream; an off-by-one tap or an `sdo` on the wrong edge shifts the whole captured vector. It writes while deselected and while `upd_n` is high, which exposes a missing enable gate or a latch that passes data at the wrong level. It resets over a loaded staging rank: a reset that also cleared staging would leave the outputs empty after the next update. It also stores disabled entries with nonzero selects, so an ungated select field would leak onto the outputs.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

   // how the staging rank is loaded, decoded from the mode pin
   typedef enum logic {
      LOAD_SERIAL   = 1'b0,
      LOAD_PARALLEL = 1'b1
   } load_mode_e;

   // entry = enable flag on top of a select field wide enough for every input
   function automatic int entry_width(input int n_in);
      return $clog2(n_in) + 1;
   endfunction

endpackage

// File: rtl/xbar_cfg_stage.sv
// Staging rank: shift chain with a per-entry parallel write port.
module xbar_cfg_stage
   import xbar_cfg_pkg::*;
#(
   parameter int N_OUT = 16,
   parameter int N_IN  = 16,
   localparam int EW     = entry_width(N_IN),
   localparam int CW     = N_OUT * EW,
   localparam int ADDR_W = $clog2(N_OUT)
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  load_mode_e        mode,
   input  logic              sdi,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [EW-1:0]     wdata,
   output logic [CW-1:0]     chain,
   output logic              sdo
);

   logic [CW-1:0] shifted;
   logic [CW-1:0] chain_nxt;

   assign shifted = {chain[CW-2:0], sdi};

   for (genvar k = 0; k < N_OUT; k++) begin : g_entry
      assign chain_nxt[k*EW +: EW] =
         (mode == LOAD_PARALLEL) ?
            ((waddr == ADDR_W'(k)) ? wdata : chain[k*EW +: EW]) :
            shifted[k*EW +: EW];

      AST_PAR_ISOLATE: assert property (@(negedge sclk) disable iff (!rst_n)
         (!ce_n && mode == LOAD_PARALLEL && waddr != ADDR_W'(k))
            |=> $stable(chain[k*EW +: EW]))
         else $error("untargeted entry %0d changed", k); // R6
   end

   always_ff @(negedge sclk) begin
      if (!ce_n) chain <= chain_nxt;
   end

   assign sdo = chain[CW-1];

   AST_HOLD_DESEL: assert property (@(negedge sclk) disable iff (!rst_n)
      ce_n |=> $stable(chain))
      else $error("staging changed while deselected"); // R5

   AST_SDO_STEP: assert property (@(negedge sclk) disable iff (!rst_n)
      (!ce_n && mode == LOAD_SERIAL) |=> (sdo == $past(chain[CW-2])))
      else $error("serial out did not advance one stage"); // R8

endmodule

// File: rtl/xbar_cfg_live.sv
// Live rank: level-sensitive latch, transparent while update is low.
module xbar_cfg_live #(
   parameter int CW = 80
) (
   input  logic          sclk,
   input  logic          rst_n,
   input  logic          upd_n,
   input  logic [CW-1:0] staged,
   output logic [CW-1:0] live
);

   always_latch begin
      if (!rst_n)     live <= '0;
      else if (!upd_n) live <= staged;
   end

   always @(negedge sclk) begin
      if (!rst_n) begin
         AST_RST_CLEAR: assert (live == '0)
            else $error("live rank not cleared in reset"); // R7
      end
   end

   AST_HOLD_UPD: assert property (@(negedge sclk) disable iff (!rst_n)
      (upd_n && $past(upd_n)) |-> $stable(live))
      else $error("live rank moved with update high"); // R4

endmodule

// File: rtl/xbar_cfg_decode.sv
// Splits the live rank into per-output enable and gated select lines.
module xbar_cfg_decode
   import xbar_cfg_pkg::*;
#(
   parameter int N_OUT = 16,
   parameter int N_IN  = 16,
   localparam int EW    = entry_width(N_IN),
   localparam int SEL_W = EW - 1,
   localparam int CW    = N_OUT * EW
) (
   input  logic [CW-1:0]          live,
   output logic [N_OUT-1:0]       out_en,
   output logic [N_OUT*SEL_W-1:0] out_sel
);

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      logic             en_k;
      logic [SEL_W-1:0] sel_k;
      assign en_k  = live[k*EW + SEL_W];
      assign sel_k = live[k*EW +: SEL_W];
      assign out_en[k] = en_k;
      assign out_sel[k*SEL_W +: SEL_W] = en_k ? sel_k : '0; // R9
   end

endmodule

// File: rtl/xbar_cfg_regs.sv
// Double-buffered routing configuration for an N_OUT x N_IN crosspoint.
module xbar_cfg_regs
   import xbar_cfg_pkg::*;
#(
   parameter int N_OUT = 16,
   parameter int N_IN  = 16,
   localparam int EW     = entry_width(N_IN),
   localparam int SEL_W  = EW - 1,
   localparam int CW     = N_OUT * EW,
   localparam int ADDR_W = $clog2(N_OUT)
) (
   input  logic                   sclk,
   input  logic                   rst_n,
   input  logic                   ce_n,
   input  logic                   par_sel,
   input  logic                   sdi,
   output logic                   sdo,
   input  logic [ADDR_W-1:0]      waddr,
   input  logic [EW-1:0]          wdata,
   input  logic                   upd_n,
   output logic [N_OUT-1:0]       out_en,
   output logic [N_OUT*SEL_W-1:0] out_sel
);

   if (N_OUT < 2) begin : g_bad_out
      $error("N_OUT must be at least 2");
   end
   if (N_IN < 2) begin : g_bad_in
      $error("N_IN must be at least 2");
   end

   logic [CW-1:0] staged;
   logic [CW-1:0] live;

   xbar_cfg_stage #(.N_OUT(N_OUT), .N_IN(N_IN)) u_stage (
      .sclk  (sclk),
      .rst_n (rst_n),
      .ce_n  (ce_n),
      .mode  (load_mode_e'(par_sel)),
      .sdi   (sdi),
      .waddr (waddr),
      .wdata (wdata),
      .chain (staged),
      .sdo   (sdo)
   );

   xbar_cfg_live #(.CW(CW)) u_live (
      .sclk   (sclk),
      .rst_n  (rst_n),
      .upd_n  (upd_n),
      .staged (staged),
      .live   (live)
   );

   xbar_cfg_decode #(.N_OUT(N_OUT), .N_IN(N_IN)) u_decode (
      .live    (live),
      .out_en  (out_en),
      .out_sel (out_sel)
   );

endmodule

// File: tb/xbar_cfg_regs_tb.sv
module xbar_cfg_regs_tb;

   localparam int NO = 16;
   localparam int EW = 5;
   localparam int CW = NO * EW;

   logic sclk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, par_sel = 1'b0, sdi = 1'b0, upd_n = 1'b1;
   logic [3:0] waddr = '0;
   logic [4:0] wdata = '0;
   logic sdo;
   logic [NO-1:0] out_en;
   logic [NO*4-1:0] out_sel;

   always #5 sclk = ~sclk;

   xbar_cfg_regs u_dut (
      .sclk(sclk), .rst_n(rst_n), .ce_n(ce_n), .par_sel(par_sel), .sdi(sdi), .sdo(sdo),
      .waddr(waddr), .wdata(wdata), .upd_n(upd_n), .out_en(out_en), .out_sel(out_sel)
   );

   typedef struct {
      string          req;
      logic [NO-1:0]  en;
      logic [NO*4-1:0] sel;
   } exp_t;

   exp_t q[$];
   event mon_ev;
   int n_chk = 0, n_fail = 0;
   logic [CW-1:0] m_stage = '0;  // staging model
   logic [CW-1:0] m_live  = '0;  // live model

   // monitor: pop expectations and compare against the ports
   initial forever begin
      @(mon_ev);
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (out_en !== e.en || out_sel !== e.sel) begin
            n_fail++;
            $display("FAIL %s: en=%h sel=%h expected en=%h sel=%h",
                     e.req, out_en, out_sel, e.en, e.sel);
         end
      end
   end

   task automatic expect_live(input string req);
      exp_t e;
      e.req = req;
      for (int k = 0; k < NO; k++) begin
         e.en[k] = m_live[k*EW + 4];
         e.sel[k*4 +: 4] = m_live[k*EW + 4] ? m_live[k*EW +: 4] : 4'h0;
      end
      q.push_back(e);
      -> mon_ev;
      #1;
   endtask

   task automatic check_vec(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // serial load: stream bit CW-1 first; captures sdo ahead of each shift
   task automatic serial_load(input logic [CW-1:0] cfg, input logic sel_low, output logic [CW-1:0] seen);
      @(posedge sclk); #1;
      ce_n = ~sel_low; par_sel = 1'b0;
      for (int i = CW - 1; i >= 0; i--) begin
         sdi = cfg[i];
         seen = {seen[CW-2:0], sdo};
         @(posedge sclk); #1;
      end
      ce_n = 1'b1;
      if (sel_low) m_stage = cfg;
      if (!upd_n) m_live = m_stage;
   endtask

   task automatic par_write(input logic [3:0] a, input logic [4:0] d, input logic sel_low);
      @(posedge sclk); #1;
      ce_n = ~sel_low; par_sel = 1'b1; waddr = a; wdata = d;
      @(posedge sclk); #1;
      ce_n = 1'b1; par_sel = 1'b0;
      if (sel_low) m_stage[a*EW +: EW] = d;
      if (!upd_n) m_live = m_stage;
   endtask

   task automatic pulse_update();
      @(posedge sclk); #1; upd_n = 1'b0;
      @(posedge sclk); #1; upd_n = 1'b1;
      m_live = m_stage;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [CW-1:0] pat_a, pat_b, pat_c, seen;
      for (int k = 0; k < NO; k++) begin
         pat_a[k*EW +: EW] = {(k % 3) != 0, 4'(15 - k)};   // some disabled with nonzero select
         pat_b[k*EW +: EW] = {1'b1, 4'(k)};
         pat_c[k*EW +: EW] = {1'b1, 4'(k * 7)};
      end

      repeat (4) @(posedge sclk);
      #1;
      expect_live("R7 reset state");
      rst_n = 1'b1;

      serial_load(pat_a, 1'b1, seen);
      expect_live("R4 hold during serial load");
      pulse_update();
      expect_live("R1 R2 R9 pattern A routed");

      serial_load(pat_b, 1'b1, seen);
      check_vec("R8 sdo replays previous stream", seen, pat_a);
      expect_live("R4 hold before update");
      pulse_update();
      expect_live("R2 R3 pattern B routed");

      serial_load(pat_a, 1'b0, seen);
      pulse_update();
      expect_live("R5 serial ignored when deselected");

      par_write(4'd3, 5'b1_1010, 1'b1);
      expect_live("R4 hold after parallel write");
      pulse_update();
      expect_live("R6 single entry written");
      par_write(4'd7, 5'b0_0110, 1'b0);
      pulse_update();
      expect_live("R5 parallel ignored when deselected");

      @(posedge sclk); #1; upd_n = 1'b0; m_live = m_stage;
      par_write(4'd12, 5'b1_0101, 1'b1);
      expect_live("R3 transparent while update low");
      par_write(4'd12, 5'b0_1001, 1'b1);
      expect_live("R9 disabled entry shows select 0");
      @(posedge sclk); #1; upd_n = 1'b1;

      @(posedge sclk); #1; rst_n = 1'b0; m_live = '0;
      repeat (2) @(posedge sclk);
      #1;
      expect_live("R7 reset clears live rank");
      rst_n = 1'b1;
      @(posedge sclk); #1;
      expect_live("R7 stays clear until update");
      pulse_update();
      expect_live("R7 staging kept across reset");

      serial_load(pat_c, 1'b1, seen);
      pulse_update();
      expect_live("R1 full rewrite pattern C");

      repeat (2) @(posedge sclk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule